// File: doc/BRIEF.md
# Replay-Aware Thread Issue Scheduler

This block decides which of several hardware threads may place its next transaction into the first stage of an in-order, time-shared pipeline. Whenever the pipeline front signals that it can take new work, the scheduler names one thread, chosen among those whose activity flag is set. By default it rotates through the threads one grant at a time, so that consecutive pipeline slots go to different threads where possible.

Stages deeper in the pipeline may cancel a thread that hit a long-latency event and ask for it to be re-run later. The scheduler takes such a request, keeps the cancelled thread out of the next few grants while others proceed, and falls back to it when nothing else can run. A mode input switches to block issue, in which one thread keeps the pipeline for a bounded burst before the next thread gets a turn. A periodic one-cycle inhibit output tells the pipeline stages to stop cancelling for a moment, so that two threads cancelling each other cannot starve forever.

Top module: `mt_issue_sched`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `sel_valid` and `no_replay` are 0 and `sel_tid` equals NTHR-1 (3 by default).
- R2: A clock edge at which `issue_en` is 1 and some thread is eligible makes `sel_valid` 1 for the following cycle with the chosen thread on `sel_tid`; an edge with `issue_en` at 0 makes `sel_valid` 0 and leaves `sel_tid` unchanged.
- R3: In interleaved mode (`blk_mode` = 0), the chosen thread is the first eligible one found by counting upward from the previous `sel_tid` plus one, wrapping after NTHR-1; the previous thread itself is checked last.
- R4: A thread whose bit in `thr_active` is 0 is never chosen.
- R5: When `issue_en` is 1 but no bit of `thr_active` is set, `sel_valid` goes to 0 and `sel_tid` keeps its value.
- R6: A replay request (`rpl_req` = 1 naming `rpl_tid`) excludes that thread from a grant made in the same cycle and from the next 2 cycles in which `issue_en` is 1.
- R7: If every active thread is currently excluded by replay requests, the exclusions are disregarded and selection proceeds among the active threads.
- R8: In block mode (`blk_mode` = 1), a thread that has just been switched to receives 16 consecutive grants (its own burst counter runs 0 to 15); on the grant after the counter reached 15 the scheduler moves on as in R3 and the counter restarts at 0.
- R9: In block mode, if the thread holding the pipeline becomes ineligible (inactive or replay-excluded), the next grant moves on at once as in R3 and the burst counter restarts.
- R10: `no_replay` is high for exactly one cycle in every 64; its first pulse follows the 64th clock edge after reset is released.
- R11: A replay request presented while `no_replay` is high is ignored: it excludes no thread.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_en | input | 1 | First pipeline stage can accept a transaction this cycle |
| thr_active | input | NTHR | Per-thread activity flags, 1 = thread may run |
| rpl_req | input | 1 | A pipeline stage cancelled a thread and asks for re-execution |
| rpl_tid | input | TIDW | Thread named by the replay request |
| blk_mode | input | 1 | 0 = interleaved issue, 1 = block issue |
| sel_tid | output | TIDW | Registered thread chosen for the first stage |
| sel_valid | output | 1 | Registered flag, `sel_tid` carries a fresh grant |
| no_replay | output | 1 | Registered periodic replay-inhibit pulse |

## Verification
Every result of this block sits one register away from its cause: a grant, a hold-off or a burst switch caused by inputs present at a clock edge shows on `sel_tid` and `sel_valid` in the cycle after that edge, and the inhibit pulse appears after the edge on which the period counter wraps. The bench therefore drives all inputs on the falling edge, advances a reference model of the grant, exclusion, burst and period state by exactly one step per rising edge, and compares the outputs 1 ns after that rising edge. Since the model sees the `no_replay` value the design shows during the request cycle, requests that coincide with an inhibit pulse are judged against the same cycle the design uses.

// File: rtl/mt_sched_pkg.sv
package mt_sched_pkg;

  typedef enum logic {
    POL_INTERLEAVE = 1'b0,
    POL_BLOCK      = 1'b1
  } sched_pol_e;

endpackage

// File: rtl/mt_rr_pick.sv
// Rotating first-set finder: searches the mask starting one position above
// the base index and wraps; the base position itself has lowest priority.
module mt_rr_pick #(
  parameter int NTHR = 4,
  parameter int TIDW = $clog2(NTHR)
) (
  input  logic [NTHR-1:0] mask,
  input  logic [TIDW-1:0] base,
  output logic            found,
  output logic [TIDW-1:0] pick
);

  always_comb begin
    found = 1'b0;
    pick  = base;
    // descending offset so the smallest offset wins
    for (int k = NTHR; k >= 1; k--) begin
      int idx;
      idx = (int'(base) + k) % NTHR;
      if (mask[idx]) begin
        found = 1'b1;
        pick  = TIDW'(idx);
      end
    end
  end

endmodule

// File: rtl/mt_hold_track.sv
// Per-thread replay hold-off counters; each counts scheduling slots.
module mt_hold_track #(
  parameter int NTHR       = 4,
  parameter int TIDW       = $clog2(NTHR),
  parameter int HOLD_SLOTS = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            slot,
  input  logic            set,
  input  logic [TIDW-1:0] set_tid,
  output logic [NTHR-1:0] held
);

  localparam int HW = $clog2(HOLD_SLOTS + 1);

  for (genvar g = 0; g < NTHR; g++) begin : g_thr
    logic [HW-1:0] cnt;
    logic          hit;

    assign hit     = set && (set_tid == TIDW'(g));
    assign held[g] = (cnt != '0) || hit;

    always_ff @(posedge clk) begin
      if (rst) begin
        cnt <= '0;
      end else if (hit) begin
        cnt <= HW'(HOLD_SLOTS);
      end else if (slot && cnt != '0) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

endmodule

// File: rtl/mt_pulse_gen.sv
// Free-running divider: registered one-cycle pulse once every PERIOD cycles.
module mt_pulse_gen #(
  parameter int PERIOD = 64
) (
  input  logic clk,
  input  logic rst,
  output logic pulse
);

  localparam int PW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [PW-1:0] LAST = PW'(PERIOD - 1);

  logic [PW-1:0] phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= '0;
      pulse <= 1'b0;
    end else begin
      pulse <= (phase == LAST);
      phase <= (phase == LAST) ? '0 : phase + 1'b1;
    end
  end

endmodule

// File: rtl/mt_issue_sched.sv
module mt_issue_sched
  import mt_sched_pkg::*;
#(
  parameter int NTHR       = 4,
  parameter int TIDW       = $clog2(NTHR),
  parameter int HOLD_SLOTS = 2,
  parameter int BURST_W    = 4,
  parameter int NR_PERIOD  = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            issue_en,
  input  logic [NTHR-1:0] thr_active,
  input  logic            rpl_req,
  input  logic [TIDW-1:0] rpl_tid,
  input  logic            blk_mode,
  output logic [TIDW-1:0] sel_tid,
  output logic            sel_valid,
  output logic            no_replay
);

  localparam logic [BURST_W-1:0] BURST_MAX = '1;

  sched_pol_e         pol;
  logic               rpl_take;
  logic [NTHR-1:0]    held;
  logic [NTHR-1:0]    cand;
  logic [NTHR-1:0]    elig;
  logic               any_elig;
  logic               rr_found;
  logic [TIDW-1:0]    rr_tid;
  logic               stay;
  logic [BURST_W-1:0] burst;

  assign pol      = blk_mode ? POL_BLOCK : POL_INTERLEAVE;
  assign rpl_take = rpl_req && !no_replay;

  mt_hold_track #(
    .NTHR      (NTHR),
    .TIDW      (TIDW),
    .HOLD_SLOTS(HOLD_SLOTS)
  ) u_hold (
    .clk    (clk),
    .rst    (rst),
    .slot   (issue_en),
    .set    (rpl_take),
    .set_tid(rpl_tid),
    .held   (held)
  );

  // exclusions only apply while some active thread is left over
  assign cand     = thr_active & ~held;
  assign elig     = (cand != '0) ? cand : thr_active;
  assign any_elig = (elig != '0);

  mt_rr_pick #(
    .NTHR(NTHR),
    .TIDW(TIDW)
  ) u_pick (
    .mask (elig),
    .base (sel_tid),
    .found(rr_found),
    .pick (rr_tid)
  );

  assign stay = (pol == POL_BLOCK) && (burst != BURST_MAX) && elig[sel_tid];

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_tid   <= TIDW'(NTHR - 1);
      sel_valid <= 1'b0;
      burst     <= BURST_MAX;
    end else if (issue_en && any_elig) begin
      sel_valid <= 1'b1;
      if (stay) begin
        burst <= burst + 1'b1;
      end else begin
        if (rr_found) sel_tid <= rr_tid;
        burst <= (pol == POL_BLOCK) ? '0 : BURST_MAX;
      end
    end else begin
      sel_valid <= 1'b0;
    end
  end

  mt_pulse_gen #(
    .PERIOD(NR_PERIOD)
  ) u_nr (
    .clk  (clk),
    .rst  (rst),
    .pulse(no_replay)
  );

endmodule

// File: rtl/mt_issue_sched_chk.sv
module mt_issue_sched_chk #(
  parameter int NTHR = 4,
  parameter int TIDW = $clog2(NTHR)
) (
  input logic            clk,
  input logic            rst,
  input logic            issue_en,
  input logic [NTHR-1:0] thr_active,
  input logic [TIDW-1:0] sel_tid,
  input logic            sel_valid,
  input logic            no_replay
);

  logic [NTHR-1:0] act_q;

  always_ff @(posedge clk) begin
    if (rst) act_q <= '0;
    else     act_q <= thr_active;
  end

  AST_GRANT_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    sel_valid |-> $past(issue_en)); // R2

  AST_IDLE_KEEPS_TID: assert property (@(posedge clk) disable iff (rst)
    !issue_en |=> ($stable(sel_tid) && !sel_valid)); // R2

  AST_GRANT_IS_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    sel_valid |-> act_q[sel_tid]); // R4

  AST_NONE_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    (issue_en && thr_active == '0) |=> (!sel_valid && $stable(sel_tid))); // R5

  AST_INHIBIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    no_replay |=> !no_replay); // R10

endmodule

bind mt_issue_sched mt_issue_sched_chk #(
  .NTHR(NTHR),
  .TIDW(TIDW)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .issue_en  (issue_en),
  .thr_active(thr_active),
  .sel_tid   (sel_tid),
  .sel_valid (sel_valid),
  .no_replay (no_replay)
);

// File: tb/mt_issue_sched_bench.sv
`timescale 1ns/1ps
module mt_issue_sched_bench;

  localparam int NT = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       issue_en = 1'b0;
  logic [3:0] thr_active = '0;
  logic       rpl_req = 1'b0;
  logic [1:0] rpl_tid = '0;
  logic       blk_mode = 1'b0;
  logic [1:0] sel_tid;
  logic       sel_valid;
  logic       no_replay;

  int n_chk = 0;
  int n_bad = 0;

  // reference state
  int   m_tid;
  logic m_valid;
  int   m_burst;
  int   m_hold [NT];
  int   m_phase;
  logic m_nr;
  int   first_nr;
  int   n_steps;

  always #2 clk = ~clk;

  mt_issue_sched u_mt_issue_sched (
    .clk(clk), .rst(rst), .issue_en(issue_en), .thr_active(thr_active),
    .rpl_req(rpl_req), .rpl_tid(rpl_tid), .blk_mode(blk_mode),
    .sel_tid(sel_tid), .sel_valid(sel_valid), .no_replay(no_replay)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_tid = NT - 1; m_valid = 1'b0; m_burst = 15;
    for (int i = 0; i < NT; i++) m_hold[i] = 0;
    m_phase = 0; m_nr = 1'b0; first_nr = -1; n_steps = 0;
  endtask

  // one clock: drive on falling edge, predict, compare after the rising edge
  task automatic step(input logic e, input logic [3:0] a, input logic q,
                      input logic [1:0] t, input logic b, input string tag);
    logic       qe;
    logic [3:0] h, c, el;
    @(negedge clk);
    issue_en = e; thr_active = a; rpl_req = q; rpl_tid = t; blk_mode = b;
    qe = q && !m_nr;
    for (int i = 0; i < NT; i++) h[i] = (m_hold[i] != 0) || (qe && int'(t) == i);
    c  = a & ~h;
    el = (c != 0) ? c : a;
    if (e && el != 0) begin
      m_valid = 1'b1;
      if (b && m_burst != 15 && el[m_tid]) m_burst++;
      else begin
        for (int k = 1; k <= NT; k++) begin
          if (el[(m_tid + k) % NT]) begin m_tid = (m_tid + k) % NT; break; end
        end
        m_burst = b ? 0 : 15;
      end
    end else m_valid = 1'b0;
    for (int i = 0; i < NT; i++) begin
      if (qe && int'(t) == i) m_hold[i] = 2;
      else if (e && m_hold[i] != 0) m_hold[i]--;
    end
    m_nr = (m_phase == 63);
    m_phase = (m_phase + 1) % 64;
    n_steps++;
    if (m_nr && first_nr < 0) first_nr = n_steps;
    @(posedge clk);
    #1;
    check({tag, " valid"}, int'(sel_valid), int'(m_valid));
    check({tag, " tid"}, int'(sel_tid), m_tid);
    check("R10 no_replay", int'(no_replay), int'(m_nr));
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int nr_last, gap_bad;
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset valid", int'(sel_valid), 0);
    check("R1 reset tid", int'(sel_tid), 3);
    check("R1 reset no_replay", int'(no_replay), 0);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;  // first edge after release: nothing driven yet
    model_reset();
    n_steps = 1; m_phase = 1;
    check("R1 first cycle valid", int'(sel_valid), 0);
    check("R1 first cycle tid", int'(sel_tid), 3);

    // R3 rotation with all threads active: 0,1,2,3,0,...
    for (int i = 0; i < 6; i++) step(1, 4'hF, 0, 0, 0, "R3 rotate");
    // R2 idle cycles keep tid
    for (int i = 0; i < 3; i++) step(0, 4'hF, 0, 0, 0, "R2 idle");
    // R4 inactive threads skipped: only 1 and 3
    for (int i = 0; i < 5; i++) step(1, 4'b1010, 0, 0, 0, "R4 skip");
    // R5 nothing active
    for (int i = 0; i < 3; i++) step(1, 4'b0000, 0, 0, 0, "R5 none");
    // R6 replay of thread 1 while tid points at 3 -> 0, then 2,3,0,1
    step(1, 4'hF, 0, 0, 0, "R3 realign");
    step(1, 4'hF, 1, 2'd1, 0, "R6 replay slot");
    for (int i = 0; i < 5; i++) step(1, 4'hF, 0, 0, 0, "R6 hold-off");
    // R6 request without a slot, then two slots excluded
    step(0, 4'hF, 1, 2'd2, 0, "R6 replay idle");
    for (int i = 0; i < 4; i++) step(1, 4'hF, 0, 0, 0, "R6 hold-off idle");
    // R7 only active thread replayed: still granted
    step(1, 4'b0100, 1, 2'd2, 0, "R7 sole thread");
    step(1, 4'b0100, 0, 0, 0, "R7 sole thread");
    step(1, 4'b0110, 1, 2'd1, 0, "R7 both held");
    step(1, 4'b0110, 1, 2'd2, 0, "R7 both held");
    // R8 block bursts of 16 then move on
    for (int i = 0; i < 40; i++) step(1, 4'hF, 0, 0, 1, "R8 burst");
    // R9 owner drops out mid-burst
    step(1, 4'hF & ~(4'b1 << m_tid), 0, 0, 1, "R9 owner inactive");
    for (int i = 0; i < 4; i++) step(1, 4'hF, 0, 0, 1, "R9 burst restart");
    step(1, 4'hF, 1, 2'(m_tid), 1, "R9 owner replayed");
    for (int i = 0; i < 3; i++) step(1, 4'hF, 0, 0, 1, "R9 after replay");
    // R11 request while inhibit is high
    while (!m_nr) step(0, 4'hF, 0, 0, 0, "R10 wait");
    step(1, 4'hF, 1, 2'((m_tid + 1) % NT), 0, "R11 inhibited replay");
    step(1, 4'hF, 0, 0, 0, "R11 after");
    // R10 spacing over a long window
    nr_last = -1; gap_bad = 0;
    for (int i = 0; i < 3000; i++) begin
      logic [1:0] t;
      t = 2'($urandom_range(0, 3));
      step(($urandom_range(0, 3) != 0), 4'($urandom_range(0, 15)),
           ($urandom_range(0, 3) == 0), t, ($urandom_range(0, 7) == 0),
           "R3 random");
      if (no_replay) begin
        if (nr_last >= 0 && n_steps - nr_last != 64) gap_bad++;
        nr_last = n_steps;
      end
    end
    check("R10 pulse spacing errors", gap_bad, 0);
    check("R10 first pulse edge", first_nr, 64);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule